// File: doc/BRIEF.md
# ATA Task-File Register Interface

This block is the host-facing register set of one ATA device sitting on a bus shared with a second device. The host reaches it through a 3-bit register address, a select line for the control block, and an 8-bit data path. Both devices see every access. Each device decides for itself whether to answer or to act, based on the device-select bit in its device/head register.

The block holds the data, error, feature, sector-count, three LBA bytes, device/head, status and control registers. Reads are filtered in three ways: by media presence, by device selection, and by the BSY bit. Reading the primary status register clears the interrupt request. Writing a set software-reset bit in control puts the device through a timed reset. A write to the command address goes to a small opcode decoder. The decoder completes any opcode from a parameterised list and aborts every other opcode. The written feature byte is presented on an output for a downstream command engine.

Top module: `ata_taskfile`

## Requirements
- R1: While `media_present` is low, every read returns 0xFF and every write leaves all registers and `intrq` unchanged.
- R2: When bit 4 of the device/head register (address 6) differs from parameter `DEV_ID`, every read returns 0xFF and `intrq` is not cleared.
- R3: A selected read at address 7 with `ctl_sel` low returns status and clears `intrq` at the clock edge. A read with `ctl_sel` high returns the same status and leaves `intrq` unchanged.
- R4: While status bit 7 (BSY) is set, a selected read at any address returns the status value.
- R5: A write at address 1 with `ctl_sel` low updates `feature` on the next edge. The error register, which is read at address 1, is not changed by that write.
- R6: A write to addresses 0 and 2 to 6 stores the byte, and a later selected read with BSY clear returns it.
- R7: A write with `ctl_sel` high stores the control byte. If control bit 2 is set after any non-command, non-feature write, a software reset starts: status becomes 0x80, `intrq` drops, and error, count and LBA0 become 0x01 while LBA1, LBA2, data and device/head become 0x00. Exactly `RST_CYCLES` edges later, status becomes 0x50.
- R8: A command write (address 7, `ctl_sel` low) while the device is unselected is ignored, unless the opcode is 0x90.
- R9: A command write while status bit 6 (DRDY) is clear is ignored.
- R10: An accepted opcode found in `OP_LIST` sets status to 0x50, error to 0x00 and raises `intrq`.
- R11: An accepted opcode not found in `OP_LIST` sets status to 0x51 (DSC, DRDY and ERR) and error to 0x04 (ABRT), and raises `intrq`.
- R12: After `rst_n` the status is 0x50, `intrq` is low, `feature` is 0x00, and the other registers hold the R7 signature values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| media_present | input | 1 | High when a medium is attached |
| ctl_sel | input | 1 | Selects the control block: control on write, alternate status on read |
| reg_addr | input | 3 | Task-file register address |
| rd_en | input | 1 | Host read strobe, one cycle |
| wr_en | input | 1 | Host write strobe, one cycle |
| wr_data | input | 8 | Host write data |
| rd_data | output | 8 | Read data, combinational from the current address |
| feature | output | 8 | Last feature byte written |
| intrq | output | 1 | Interrupt request |

## Verification
The assertions assume that the host never raises `rd_en` and `wr_en` in the same cycle. Under that assumption, a status read cannot coincide with a command that sets `intrq`. The bench keeps to this by issuing at most one strobe per cycle from its access tasks. It changes `media_present` only between accesses, and it reaches the software-reset path only through directed sequences, never through the random mix.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;
  localparam logic [7:0] ST_BSY  = 8'h80;
  localparam logic [7:0] ST_DRDY = 8'h40;
  localparam logic [7:0] ST_DSC  = 8'h10;
  localparam logic [7:0] ST_DRQ  = 8'h08;
  localparam logic [7:0] ST_ERR  = 8'h01;
  localparam logic [7:0] ER_ABRT = 8'h04;
  localparam int         CT_SRST_BIT = 2;
  localparam int         DH_DEV_BIT  = 4;
  localparam logic [2:0] A_FEAT = 3'd1;
  localparam logic [2:0] A_DEVH = 3'd6;
  localparam logic [2:0] A_CMD  = 3'd7;
  localparam logic [7:0] OP_DIAG = 8'h90;
  localparam logic [7:0] ST_READY = ST_DRDY | ST_DSC;
  localparam logic [7:0] ST_ABORT = ST_DRDY | ST_DSC | ST_ERR;

  typedef enum logic {TF_IDLE, TF_RESET} tf_state_e;

  function automatic logic dev_match(input logic [7:0] devh, input logic id);
    return devh[DH_DEV_BIT] == id;
  endfunction

  // power-on / software-reset signature per address
  function automatic logic [7:0] sig_value(input logic [2:0] a);
    case (a)
      3'd1, 3'd2, 3'd3: return 8'h01;
      default:          return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/ata_cmd_decode.sv
module ata_cmd_decode #(
  parameter int NUM_OPS = 3,
  parameter logic [NUM_OPS*8-1:0] OP_LIST = 24'h90_EC_E7
) (
  input  logic [7:0] opcode,
  output logic       known
);
  logic [NUM_OPS-1:0] hit;
  for (genvar i = 0; i < NUM_OPS; i++) begin : g_op
    assign hit[i] = (opcode == OP_LIST[i*8 +: 8]);
  end
  assign known = |hit;
endmodule

// File: rtl/ata_srst_timer.sv
module ata_srst_timer #(
  parameter int CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (start)           cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == CW'(1)) && !start;
endmodule

// File: rtl/ata_taskfile.sv
module ata_taskfile
  import ata_tf_pkg::*;
#(
  parameter logic DEV_ID     = 1'b0,
  parameter int   RST_CYCLES = 8,
  parameter int   NUM_OPS    = 3,
  parameter logic [NUM_OPS*8-1:0] OP_LIST = 24'h90_EC_E7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       media_present,
  input  logic       ctl_sel,
  input  logic [2:0] reg_addr,
  input  logic       rd_en,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic [7:0] feature,
  output logic       intrq
);
  logic [7:0] tf_q [0:7];   // index 1 is the error register, 7 unused
  logic [7:0] status_q, ctrl_q, feat_q;
  logic       intrq_q;
  tf_state_e  state_q;

  // named internal events
  logic       selected, stat_rd_clr, wr_feat, wr_plain, srst_fire;
  logic       cmd_wr, cmd_accept, cmd_known, tmr_done, rst_done, in_reset;
  logic [7:0] ctrl_next, err_q;

  assign selected    = dev_match(tf_q[A_DEVH], DEV_ID);
  assign err_q       = tf_q[A_FEAT];
  assign in_reset    = (state_q == TF_RESET);
  assign stat_rd_clr = media_present && selected && rd_en && !ctl_sel && reg_addr == A_CMD;
  assign wr_feat     = media_present && wr_en && !ctl_sel && reg_addr == A_FEAT;
  assign wr_plain    = media_present && wr_en &&
                       (ctl_sel || (reg_addr != A_CMD && reg_addr != A_FEAT));
  assign ctrl_next   = ctl_sel ? wr_data : ctrl_q;
  assign srst_fire   = wr_plain && ctrl_next[CT_SRST_BIT];
  assign cmd_wr      = media_present && wr_en && !ctl_sel && reg_addr == A_CMD;
  assign cmd_accept  = cmd_wr && (selected || wr_data == OP_DIAG) && status_q[6];
  assign rst_done    = tmr_done && in_reset;

  ata_cmd_decode #(.NUM_OPS(NUM_OPS), .OP_LIST(OP_LIST)) u_dec (
    .opcode (wr_data),
    .known  (cmd_known)
  );

  ata_srst_timer #(.CYCLES(RST_CYCLES)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .start (srst_fire),
    .done  (tmr_done)
  );

  always_comb begin
    if (!media_present || !selected)
      rd_data = 8'hFF;
    else if (ctl_sel || reg_addr == A_CMD || status_q[7])
      rd_data = status_q;
    else
      rd_data = tf_q[reg_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) tf_q[i] <= sig_value(3'(i));
      status_q <= ST_READY;
      ctrl_q   <= 8'h00;
      feat_q   <= 8'h00;
      intrq_q  <= 1'b0;
      state_q  <= TF_IDLE;
    end else begin
      if (stat_rd_clr) intrq_q <= 1'b0;
      if (wr_feat)     feat_q  <= wr_data;
      if (wr_plain) begin
        if (ctl_sel) ctrl_q <= wr_data;
        else         tf_q[reg_addr] <= wr_data;
      end
      if (srst_fire) begin
        for (int i = 0; i < 8; i++) tf_q[i] <= sig_value(3'(i));
        status_q <= ST_BSY;
        intrq_q  <= 1'b0;
        state_q  <= TF_RESET;
      end else if (rst_done) begin
        status_q <= ST_READY;
        state_q  <= TF_IDLE;
      end
      if (cmd_accept) begin
        state_q <= TF_IDLE;
        intrq_q <= 1'b1;
        if (cmd_known) begin
          status_q      <= ST_READY;
          tf_q[A_FEAT]  <= 8'h00;
        end else begin
          status_q      <= ST_ABORT;
          tf_q[A_FEAT]  <= ER_ABRT;
        end
      end
    end
  end

  assign feature = feat_q;
  assign intrq   = intrq_q;
endmodule

// File: rtl/ata_taskfile_chk.sv
module ata_taskfile_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       media_present,
  input logic       ctl_sel,
  input logic [2:0] reg_addr,
  input logic       rd_en,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       intrq,
  input logic [7:0] status_q,
  input logic [7:0] err_q,
  input logic       selected,
  input logic       cmd_accept,
  input logic       cmd_known,
  input logic       srst_fire,
  input logic       in_reset
);
  AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(rd_en && wr_en)); // R3
  AST_NOMEDIA_FF: assert property (@(posedge clk) disable iff (!rst_n)
    (!media_present && rd_en) |-> rd_data == 8'hFF); // R1
  AST_DESEL_FF: assert property (@(posedge clk) disable iff (!rst_n)
    (media_present && !selected && rd_en) |-> rd_data == 8'hFF); // R2
  AST_STATUS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && media_present && selected && !ctl_sel && reg_addr == 3'd7) |=> !intrq); // R3
  AST_ALT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && ctl_sel && intrq) |=> intrq); // R3
  AST_BUSY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && media_present && selected && status_q[7]) |-> rd_data == status_q); // R4
  AST_SRST_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    srst_fire |=> (status_q == 8'h80 && !intrq && in_reset)); // R7
  AST_RESET_BSY: assert property (@(posedge clk) disable iff (!rst_n)
    in_reset |-> status_q[7]); // R7
  AST_UNSEL_DIAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_accept && !selected) |-> wr_data == 8'h90); // R8
  AST_DRDY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept |-> status_q[6]); // R9
  AST_CMD_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_accept && cmd_known) |=> (status_q == 8'h50 && err_q == 8'h00 && intrq)); // R10
  AST_CMD_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_accept && !cmd_known) |=> (status_q == 8'h51 && err_q == 8'h04 && intrq)); // R11
endmodule

bind ata_taskfile ata_taskfile_chk chk_i (
  .clk(clk), .rst_n(rst_n), .media_present(media_present), .ctl_sel(ctl_sel),
  .reg_addr(reg_addr), .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .intrq(intrq), .status_q(status_q), .err_q(err_q),
  .selected(selected), .cmd_accept(cmd_accept), .cmd_known(cmd_known),
  .srst_fire(srst_fire), .in_reset(in_reset)
);

// File: tb/ata_taskfile_tb.sv
module ata_taskfile_tb_top;
  localparam int CLK_P = 10;
  localparam int RSTC  = 8;

  logic clk = 1'b0, rst_n = 1'b0, media_present = 1'b1, ctl_sel = 1'b0;
  logic [2:0] reg_addr = '0;
  logic rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = '0, rd_data, feature;
  logic intrq;
  int checks = 0, failures = 0;

  always #(CLK_P/2) clk = ~clk;

  ata_taskfile #(.DEV_ID(1'b0), .RST_CYCLES(RSTC)) dut_i (
    .clk(clk), .rst_n(rst_n), .media_present(media_present), .ctl_sel(ctl_sel),
    .reg_addr(reg_addr), .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .feature(feature), .intrq(intrq)
  );

  // bench model
  logic [7:0] m_reg [0:7];   // 1 = error, 7 = status
  logic [7:0] m_ctrl, m_feat;
  logic       m_intrq;

  function automatic logic [7:0] sig(input int a);
    return (a >= 1 && a <= 3) ? 8'h01 : 8'h00;
  endfunction

  function automatic logic supported(input logic [7:0] op);
    return op == 8'h90 || op == 8'hEC || op == 8'hE7;
  endfunction

  function automatic logic [7:0] exp_rd(input logic s, input logic [2:0] a);
    if (!media_present || m_reg[6][4] != 1'b0) return 8'hFF;
    if (s || a == 3'd7 || m_reg[7][7]) return m_reg[7];
    return m_reg[a];
  endfunction

  task automatic model_sig();
    for (int i = 0; i < 7; i++) m_reg[i] = sig(i);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic s, input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    ctl_sel = s; reg_addr = a; rd_en = 1'b1;
    #1 v = rd_data;
    @(posedge clk); #1 rd_en = 1'b0;
  endtask

  task automatic do_write(input logic s, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    ctl_sel = s; reg_addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic op_read(input logic s, input logic [2:0] a, input string req);
    logic [7:0] v, e;
    e = exp_rd(s, a);
    do_read(s, a, v);
    chk(req, v, e);
    if (media_present && m_reg[6][4] == 1'b0 && !s && a == 3'd7) m_intrq = 1'b0;
    chk({req, "_intrq"}, {7'd0, intrq}, {7'd0, m_intrq});
  endtask

  task automatic op_write(input logic s, input logic [2:0] a, input logic [7:0] d, input string req);
    do_write(s, a, d);
    if (media_present) begin
      if (!s && a == 3'd1) m_feat = d;
      else if (s || a != 3'd7) begin
        if (s) m_ctrl = d; else m_reg[a] = d;
        if (m_ctrl[2]) begin model_sig(); m_reg[7] = 8'h80; m_intrq = 1'b0; end
      end else if ((m_reg[6][4] == 1'b0 || d == 8'h90) && m_reg[7][6]) begin
        m_intrq = 1'b1;
        m_reg[7] = supported(d) ? 8'h50 : 8'h51;
        m_reg[1] = supported(d) ? 8'h00 : 8'h04;
      end
    end
    chk({req, "_feat"}, feature, m_feat);
    chk({req, "_intrq"}, {7'd0, intrq}, {7'd0, m_intrq});
  endtask

  initial begin
    #(CLK_P * 150000);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int busy;
    model_sig(); m_reg[7] = 8'h50; m_ctrl = 0; m_feat = 0; m_intrq = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R12 reset state
    chk("R12_feat", feature, 8'h00);
    chk("R12_intrq", {7'd0, intrq}, 8'h00);
    for (int a = 0; a < 8; a++) op_read(1'b0, 3'(a), "R12");

    // R6 / R5 basic
    op_write(0, 3'd2, 8'hA5, "R6");
    op_read(0, 3'd2, "R6");
    op_write(0, 3'd1, 8'h3C, "R5");
    chk("R5_feat", feature, 8'h3C);
    op_read(0, 3'd1, "R5_err_unchanged");

    // R11 abort, R3 alt vs primary
    op_write(0, 3'd7, 8'h00, "R11");
    chk("R11_intrq", {7'd0, intrq}, 8'h01);
    op_read(1, 3'd0, "R3_alt");
    chk("R3_alt_keeps", {7'd0, intrq}, 8'h01);
    op_read(0, 3'd1, "R11_err");
    op_read(0, 3'd7, "R3_primary");
    chk("R3_cleared", {7'd0, intrq}, 8'h00);

    // R10 supported command
    op_write(0, 3'd7, 8'hEC, "R10");
    op_read(0, 3'd1, "R10_err");
    op_read(0, 3'd7, "R10_status");

    // R1 no media
    media_present = 1'b0;
    op_read(0, 3'd2, "R1_read");
    op_write(0, 3'd2, 8'h11, "R1_write");
    op_write(0, 3'd7, 8'h00, "R1_cmd");
    media_present = 1'b1;
    op_read(0, 3'd2, "R1_kept");
    op_read(0, 3'd7, "R1_status");

    // R2 / R8 deselected
    op_write(0, 3'd6, 8'h10, "R2_sel");
    op_read(0, 3'd7, "R2");
    op_write(0, 3'd7, 8'hEC, "R8_ignored");
    op_write(0, 3'd7, 8'h90, "R8_diag");
    chk("R8_diag_intrq", {7'd0, intrq}, 8'h01);
    op_read(0, 3'd7, "R2_noclear");
    op_write(0, 3'd6, 8'h00, "R8_resel");
    op_read(0, 3'd1, "R8_err");
    op_read(0, 3'd7, "R8_status");

    // R7 software reset, R9 command while busy, R4 busy read
    op_write(0, 3'd4, 8'h77, "R7_pre");
    op_write(1, 3'd0, 8'h04, "R7_srst");
    op_write(1, 3'd0, 8'h00, "R7_release");
    op_write(0, 3'd7, 8'hE7, "R9_busy_cmd");
    op_read(0, 3'd2, "R4_busy");
    busy = 0;
    for (int n = 0; n < 100; n++) begin
      do_read(1, 3'd0, v);
      if (v == 8'h50) break;
      busy++;
    end
    checks++;
    if (busy != RSTC - 3) begin
      failures++;
      $display("FAIL R7_timing actual=%0d expected=%0d", busy, RSTC - 3);
    end
    m_reg[7] = 8'h50;
    for (int a = 0; a < 7; a++) op_read(0, 3'(a), "R7_sig");
    chk("R9_no_intrq", {7'd0, intrq}, 8'h00);

    // constrained random mix
    void'($urandom(32'd1234));
    for (int n = 0; n < 400; n++) begin
      int k;
      logic [7:0] op;
      k = $urandom_range(0, 9);
      if (k < 4) op_read($urandom_range(0, 1) == 1, 3'($urandom_range(0, 7)), "R6_rand_rd");
      else if (k < 6) op_write(0, 3'($urandom_range(0, 5)), 8'($urandom), "R6_rand_wr");
      else if (k == 6) op_write(0, 3'd6, ($urandom_range(0, 3) == 0) ? 8'h10 : 8'h00, "R2_rand_sel");
      else begin
        case ($urandom_range(0, 4))
          0: op = 8'h90; 1: op = 8'hEC; 2: op = 8'hE7;
          default: op = 8'($urandom);
        endcase
        op_write(0, 3'd7, op, "R10_R11_rand_cmd");
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule